// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a field-configurable logic array in synthesizable logic. A register-based configuration store takes the place of fuses. It holds three things: a pair of links per input for every product term, a connection mask from every product term to the outputs, and one polarity bit per output. Data flows combinationally through the array. Each product term is the AND of the literals chosen for it. Each output is the OR of the terms connected to it, followed by an optional inversion.

Software or a boot sequencer programs one product term per clock through a write port. A second strobe loads the polarity register. An active-low enable gates the outputs, and a mode pin picks the disabled appearance. In tri-state style the block drops its single output-enable. In open-collector style every data output reads high. A synchronous reset returns the whole store to the unprogrammed map, in which no term can fire.

Top module: `sop_array`

## Requirements
- R1: The array has N_IN=16 inputs, N_TERM=48 product terms and N_OUT=8 outputs. Bit 2i of a term's link word is the true link of input i, and bit 2i+1 is its complement link; a value of 1 means the link is intact. An intact true link requires din[i]=1, an intact complement link requires din[i]=0, and a term is 1 only when every intact link is satisfied.
- R2: An input with both links intact makes its term 0 for every input value. An input with both links removed (00) is a don't-care and has no effect on the term.
- R3: Bit j of a term's OR mask connects that term to output j. A removed connection contributes 0. Any term may drive any set of outputs.
- R4: Polarity bit j set to 1 inverts output j after the OR stage. Set to 0, it passes the OR result unchanged.
- R5: Synchronous reset sets every link intact, every OR connection present and every polarity bit to 0. After reset, with ce_n low, dout reads 8'h00 for any din.
- R6: A term write is captured on the rising clock edge when cfg_we is high, and it changes dout in the same cycle that follows the edge. A polarity write via pol_we is captured the same way.
- R7: A term write whose index is 48 or above changes no stored configuration.
- R8: dout_oe equals 1 while ce_n is low and 0 while ce_n is high.
- R9: While ce_n is high, dout is 8'h00 when oc_mode is 0 (tri-state style) and 8'hFF when oc_mode is 1 (open-collector style).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous reset to the unprogrammed map, active high |
| cfg_we | input | 1 | Term write strobe |
| cfg_term | input | 6 | Index of the term to write |
| cfg_links | input | 32 | Link pairs for the term, bit 2i true, bit 2i+1 complement |
| cfg_or | input | 8 | OR connection mask for the term |
| pol_we | input | 1 | Polarity write strobe |
| pol_data | input | 8 | Polarity bits, 1 inverts |
| oc_mode | input | 1 | Disabled style: 0 tri-state, 1 open-collector |
| ce_n | input | 1 | Chip enable, active low |
| din | input | 16 | Logic inputs |
| dout | output | 8 | Logic outputs |
| dout_oe | output | 1 | Output enable for external tri-state drivers |

## Verification
The bench uses the default sizes: 16 inputs, 48 terms and 8 outputs. With these sizes the 6-bit term index has sixteen unused codes (48 to 63), so the bench can write through out-of-range indexes and confirm that they are ignored. Directed cases cover single literals, conflicting and don't-care link pairs, polarity inversion and both disabled styles. After these, the bench programs all 48 terms with sparse random literals and compares many random input vectors against an evaluator inside the bench.

// File: rtl/sop_array.sv
module sop_array #(
  parameter int N_IN   = 16,
  parameter int N_TERM = 48,
  parameter int N_OUT  = 8,
  localparam int IDX_W = $clog2(N_TERM),
  localparam int LNK_W = 2 * N_IN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_term,
  input  logic [LNK_W-1:0] cfg_links,
  input  logic [N_OUT-1:0] cfg_or,
  input  logic             pol_we,
  input  logic [N_OUT-1:0] pol_data,
  input  logic             oc_mode,
  input  logic             ce_n,
  input  logic [N_IN-1:0]  din,
  output logic [N_OUT-1:0] dout,
  output logic             dout_oe
);

  logic [LNK_W-1:0]  and_cfg [N_TERM];
  logic [N_OUT-1:0]  or_cfg  [N_TERM];
  logic [N_OUT-1:0]  pol;
  logic [N_TERM-1:0] term;
  logic [N_OUT-1:0]  sum;
  logic [N_OUT-1:0]  func;
  logic              wr_ok;

  assign wr_ok = cfg_we && (32'(cfg_term) < N_TERM);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_TERM; k++) begin
        and_cfg[k] <= '1;
        or_cfg[k]  <= '1;
      end
      pol <= '0;
    end else begin
      if (wr_ok) begin
        and_cfg[cfg_term] <= cfg_links;
        or_cfg[cfg_term]  <= cfg_or;
      end
      if (pol_we) pol <= pol_data;
    end
  end

  generate
    for (genvar k = 0; k < N_TERM; k++) begin : g_term
      logic [N_IN-1:0] lit_ok;
      for (genvar i = 0; i < N_IN; i++) begin : g_lit
        assign lit_ok[i] = (~and_cfg[k][2*i] | din[i]) &
                           (~and_cfg[k][2*i+1] | ~din[i]);
      end
      assign term[k] = &lit_ok;
    end
  endgenerate

  always_comb begin
    sum = '0;
    for (int k = 0; k < N_TERM; k++)
      if (term[k]) sum = sum | or_cfg[k];
  end

  assign func    = sum ^ pol;
  assign dout_oe = ~ce_n;
  assign dout    = ce_n ? (oc_mode ? '1 : '0) : func;

endmodule

// File: rtl/sop_array_chk.sv
module sop_array_chk #(
  parameter int N_OUT = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             oc_mode,
  input logic             ce_n,
  input logic [N_OUT-1:0] dout,
  input logic             dout_oe
);

  // R8
  oe_follows_ce_chk: assert property (@(posedge clk) disable iff (rst)
    dout_oe == !ce_n);

  // R9
  oc_disabled_high_chk: assert property (@(posedge clk) disable iff (rst)
    (ce_n && oc_mode) |-> dout == '1);

  // R9
  ts_disabled_low_chk: assert property (@(posedge clk) disable iff (rst)
    (ce_n && !oc_mode) |-> dout == '0);

  // R5
  virgin_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && !ce_n) |-> dout == '0);

endmodule

bind sop_array sop_array_chk #(.N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst(rst), .oc_mode(oc_mode), .ce_n(ce_n),
  .dout(dout), .dout_oe(dout_oe)
);

// File: tb/test_sop_array.sv
module test_sop_array;
  localparam int CLK_P  = 10;
  localparam int NI     = 16;
  localparam int NT     = 48;
  localparam int NO     = 8;

  logic          clk = 0;
  logic          rst = 1;
  logic          cfg_we = 0;
  logic [5:0]    cfg_term = '0;
  logic [31:0]   cfg_links = '0;
  logic [7:0]    cfg_or = '0;
  logic          pol_we = 0;
  logic [7:0]    pol_data = '0;
  logic          oc_mode = 0;
  logic          ce_n = 0;
  logic [15:0]   din = '0;
  logic [7:0]    dout;
  logic          dout_oe;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_and [NT];
  logic [7:0]  m_or  [NT];
  logic [7:0]  m_pol;

  always #(CLK_P/2) clk = ~clk;

  sop_array i_sop_array (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_term(cfg_term),
    .cfg_links(cfg_links), .cfg_or(cfg_or), .pol_we(pol_we),
    .pol_data(pol_data), .oc_mode(oc_mode), .ce_n(ce_n), .din(din),
    .dout(dout), .dout_oe(dout_oe)
  );

  function automatic logic [7:0] model(input logic [15:0] d);
    logic [7:0] s = '0;
    for (int k = 0; k < NT; k++) begin
      logic t = 1'b1;
      for (int i = 0; i < NI; i++) begin
        if (m_and[k][2*i] && !d[i]) t = 1'b0;
        if (m_and[k][2*i+1] && d[i]) t = 1'b0;
      end
      if (t) s = s | m_or[k];
    end
    return s ^ m_pol;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    for (int k = 0; k < NT; k++) begin
      m_and[k] = '1;
      m_or[k]  = '1;
    end
    m_pol = '0;
  endtask

  task automatic write_term(input logic [5:0] idx, input logic [31:0] lk, input logic [7:0] om);
    @(negedge clk);
    cfg_we = 1; cfg_term = idx; cfg_links = lk; cfg_or = om;
    @(negedge clk);
    cfg_we = 0;
    if (idx < NT) begin
      m_and[idx] = lk;
      m_or[idx]  = om;
    end
  endtask

  task automatic write_pol(input logic [7:0] p);
    @(negedge clk);
    pol_we = 1; pol_data = p;
    @(negedge clk);
    pol_we = 0;
    m_pol = p;
  endtask

  task automatic t_reset();
    ce_n = 0; oc_mode = 0;
    do_reset();
    foreach (din[i]) begin end
    din = 16'h0000; #1; check("R5 zero in", dout, 8'h00);
    check("R8 oe low ce", dout_oe, 1);
    din = 16'hFFFF; #1; check("R5 ones in", dout, 8'h00);
    din = 16'hA5C3; #1; check("R5 mixed in", dout, 8'h00);
  endtask

  task automatic t_single();
    do_reset();
    write_term(6'd3, 32'h1 | (32'h1 << 11), 8'h04);
    din = 16'h0001; #1; check("R1 R6 literals met", dout, 8'h04);
    din = 16'h0021; #1; check("R1 complement fails", dout, 8'h00);
    din = 16'h0000; #1; check("R1 true fails", dout, 8'h00);
    din = 16'hFFDF; #1; check("R3 only bit2", dout, 8'h04);
  endtask

  task automatic t_pair();
    do_reset();
    write_term(6'd4, 32'h3 << 4, 8'h01);
    din = 16'h0000; #1; check("R2 conflict low", dout, 8'h00);
    din = 16'hFFFF; #1; check("R2 conflict high", dout, 8'h00);
    write_term(6'd5, 32'h0, 8'h80);
    din = 16'h1234; #1; check("R2 dont care a", dout, 8'h80);
    din = 16'hFEDC; #1; check("R2 dont care b", dout, 8'h80);
    write_term(6'd47, 32'h0, 8'h18);
    #1; check("R3 last term", dout, 8'h98);
  endtask

  task automatic t_polarity();
    do_reset();
    write_pol(8'hF0);
    din = 16'h0000; #1; check("R4 R6 invert virgin", dout, 8'hF0);
    write_term(6'd10, 32'h2, 8'h81);
    din = 16'h0000; #1; check("R4 invert with term", dout, 8'h71);
    din = 16'h0001; #1; check("R4 term off", dout, 8'hF0);
  endtask

  task automatic t_oor();
    do_reset();
    write_term(6'd48, 32'h0, 8'hFF);
    din = 16'h5555; #1; check("R7 index 48", dout, 8'h00);
    write_term(6'd63, 32'h0, 8'hFF);
    #1; check("R7 index 63", dout, 8'h00);
  endtask

  task automatic t_disable();
    do_reset();
    write_term(6'd0, 32'h0, 8'h3C);
    ce_n = 1; oc_mode = 0; #1;
    check("R9 tristate data", dout, 8'h00);
    check("R8 oe off", dout_oe, 0);
    oc_mode = 1; #1;
    check("R9 opencollector data", dout, 8'hFF);
    check("R8 oe off oc", dout_oe, 0);
    ce_n = 0; #1;
    check("R8 enabled data", dout, 8'h3C);
    check("R8 oe on", dout_oe, 1);
    oc_mode = 0;
  endtask

  task automatic t_random();
    do_reset();
    for (int k = 0; k < NT; k++) begin
      logic [31:0] lk = '0;
      for (int i = 0; i < NI; i++) begin
        int r = $urandom % 10;
        if (r == 0) lk[2*i] = 1'b1;
        else if (r == 1) lk[2*i+1] = 1'b1;
      end
      write_term(6'(k), lk, 8'($urandom));
    end
    write_pol(8'($urandom));
    for (int n = 0; n < 300; n++) begin
      @(negedge clk);
      din = 16'($urandom);
      #1; check("R1 R3 random", dout, model(din));
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_single();
    t_pair();
    t_polarity();
    t_oor();
    t_disable();
    t_random();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule